// File: doc/BRIEF.md
# Single-Bank DRAM Row-Buffer Controller

This block drives one DRAM bank that owns a single row buffer. A requester presents one access at a time over a valid/ready handshake: a read or write flag, a row, a column and (for writes) a data byte. The controller compares the requested row with the row currently held in the buffer. It then issues the command sequence that the access needs on a one-command-per-cycle bank command port. The sequence is open, close-then-open, or column only.

Column reads and writes can only reach the row buffer. Opening a row empties the cells, so the buffered row has to be written back by a close before another row may be opened. Four down-counters hold the minimum spacing between commands: open-to-column, close-to-open, open-to-open and write-to-read. A parameter selects the page policy. With open-page, the row stays in the buffer so that later accesses to it are cheap. With close-page, the bank is closed straight after every access. Each access ends with a single response cycle that carries a 2-bit class code and, for reads, the data.

Top module: `dram_bank_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `cmd_valid` and `rsp_valid` are 0, no row is open, and the first access reports class 01 (empty bank).
- R2: A column command (`cmd_kind` 1 = read, 2 = write) is only issued while a row is open, i.e. after an open (`cmd_kind` 0) and before the next close (`cmd_kind` 3).
- R3: Under open-page policy an access to the open row reports class 00, issues no open or close command, and its response appears 2 cycles after the accepting edge when no timing gap is pending.
- R4: An access to an empty bank reports class 01, issues open then column, and responds 2 + T_RCD cycles after acceptance when no gap is pending.
- R5: Under open-page policy an access to a different row reports class 10, issues close, open and column in that order, and responds 2 + T_RP + T_RCD cycles after acceptance when no gap is pending. The closed row's written data survives and is read back later.
- R6: Under close-page policy a close command follows every access in the cycle of its response, so every access reports class 01 and the bank is empty after each response.
- R7: Two open commands are at least T_RC cycles apart.
- R8: A read command comes at least T_WTR cycles after the last write command.
- R9: A column command comes at least T_RCD cycles after its open, and an open at least T_RP cycles after a close.
- R10: `req_ready` is low from the accepting edge until the response cycle has passed, and exactly one single-cycle `rsp_valid` pulse is produced per accepted request.
- R11: For a read, `rsp_rdata` in the response cycle equals the current content of the addressed cell, including data written earlier. For a write, it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 00 hit, 01 empty bank, 10 conflict |
| rsp_rdata | output | DATA_W | Read data (zero for writes) |
| cmd_valid | output | 1 | Bank command issued this cycle |
| cmd_kind | output | 2 | 0 open, 1 read, 2 write, 3 close |
| cmd_row | output | ROW_W | Row for the open command |
| cmd_col | output | COL_W | Column for read/write |
| cmd_wdata | output | DATA_W | Data for write command |
| bank_rdata | input | DATA_W | Bank read data, valid the cycle after a read command |

## Verification
The hardest case to reach is an access whose command sequence runs into several timing gaps together. One example is a row conflict issued right after another conflict, where the close-to-open and open-to-open counters both hold back the open. Another is a read to the open row just after a write, where only the write-to-read counter holds it back. The directed tasks reach these cases by sending requests back to back with no idle cycles in between, after quiet periods that pin down the exact latency of the ungated cases. A behavioural bank in the bench timestamps every command and flags any spacing or open/close-order violation. It also keeps the cell array with write-back on close, so lost row data shows up as a wrong read value.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } bank_cmd_e;

  typedef enum logic [1:0] {
    ST_HIT      = 2'b00,
    ST_EMPTY    = 2'b01,
    ST_CONFLICT = 2'b10
  } access_kind_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_CLOSE,
    SQ_OPEN,
    SQ_COLUMN,
    SQ_REPLY
  } seq_state_e;

  // Value loaded on the issuing edge so that the counter reads zero
  // exactly GAP edges later.
  function automatic int unsigned gap_preload(int unsigned gap);
    return (gap > 1) ? gap - 1 : 0;
  endfunction

  function automatic int unsigned ctr_width(int unsigned gap);
    return (gap < 3) ? 1 : $clog2(gap);
  endfunction

  function automatic access_kind_e classify(logic is_open, logic row_match);
    if (!is_open)      return ST_EMPTY;
    else if (row_match) return ST_HIT;
    else               return ST_CONFLICT;
  endfunction

endpackage

// File: rtl/dbc_gap_timer.sv
module dbc_gap_timer
  import dbc_pkg::*;
#(
  parameter int unsigned GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic elapsed
);

  localparam int unsigned   CW      = ctr_width(GAP);
  localparam logic [CW-1:0] PRELOAD = CW'(gap_preload(GAP));

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= PRELOAD;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign elapsed = (cnt == '0);

  generate
    if (GAP > 1) begin : g_chk
      AST_GAP_BLOCKS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !elapsed); // R9
    end
  endgenerate

endmodule

// File: rtl/dbc_row_tracker.sv
module dbc_row_tracker
  import dbc_pkg::*;
#(
  parameter int unsigned ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_fire,
  input  logic             close_fire,
  input  logic [ROW_W-1:0] open_row_in,
  input  logic [ROW_W-1:0] probe_row,
  output logic             is_open,
  output logic [ROW_W-1:0] cur_row,
  output access_kind_e     probe_kind
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      cur_row <= '0;
    end else if (open_fire) begin
      is_open <= 1'b1;
      cur_row <= open_row_in;
    end else if (close_fire) begin
      is_open <= 1'b0;
    end
  end

  logic row_match;
  assign row_match  = (probe_row == cur_row);
  assign probe_kind = classify(is_open, row_match);

  AST_OPEN_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    open_fire |-> !is_open); // R5
  AST_CLOSE_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    close_fire |-> is_open); // R5

endmodule

// File: rtl/dbc_sequencer.sv
module dbc_sequencer
  import dbc_pkg::*;
#(
  parameter int unsigned ROW_W     = 4,
  parameter int unsigned COL_W     = 3,
  parameter int unsigned DATA_W    = 8,
  parameter bit          OPEN_PAGE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  input  access_kind_e      probe_kind,
  input  logic              rcd_ok,
  input  logic              rp_ok,
  input  logic              rc_ok,
  input  logic              wtr_ok,
  input  logic [DATA_W-1:0] bank_rdata,
  output logic              act_fire,
  output logic              pre_fire,
  output logic              rd_fire,
  output logic              wr_fire,
  output logic              cmd_valid,
  output bank_cmd_e         cmd_kind,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output access_kind_e      rsp_status,
  output logic [DATA_W-1:0] rsp_rdata
);

  seq_state_e        state, nxt;
  logic [ROW_W-1:0]  lat_row;
  logic [COL_W-1:0]  lat_col;
  logic [DATA_W-1:0] lat_wdata;
  logic              lat_wr;
  access_kind_e      lat_kind;
  logic              accept;
  logic              col_go;

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      lat_row   <= '0;
      lat_col   <= '0;
      lat_wdata <= '0;
      lat_wr    <= 1'b0;
      lat_kind  <= ST_EMPTY;
    end else begin
      state <= nxt;
      if (accept) begin
        lat_row   <= req_row;
        lat_col   <= req_col;
        lat_wdata <= req_wdata;
        lat_wr    <= req_write;
        lat_kind  <= probe_kind;
      end
    end
  end

  always_comb begin
    req_ready = 1'b0;
    act_fire  = 1'b0;
    pre_fire  = 1'b0;
    rsp_valid = 1'b0;
    col_go    = 1'b0;
    nxt       = state;
    case (state)
      SQ_IDLE: begin
        req_ready = 1'b1;
        if (accept) begin
          case (probe_kind)
            ST_HIT:   nxt = SQ_COLUMN;
            ST_EMPTY: nxt = SQ_OPEN;
            default:  nxt = SQ_CLOSE;
          endcase
        end
      end
      SQ_CLOSE: begin
        pre_fire = 1'b1;
        nxt      = SQ_OPEN;
      end
      SQ_OPEN: begin
        act_fire = rp_ok && rc_ok;
        if (act_fire) nxt = SQ_COLUMN;
      end
      SQ_COLUMN: begin
        col_go = rcd_ok && (lat_wr || wtr_ok);
        if (col_go) nxt = SQ_REPLY;
      end
      SQ_REPLY: begin
        rsp_valid = 1'b1;
        pre_fire  = !OPEN_PAGE;
        nxt       = SQ_IDLE;
      end
      default: nxt = SQ_IDLE;
    endcase
  end

  assign rd_fire   = col_go && !lat_wr;
  assign wr_fire   = col_go && lat_wr;
  assign cmd_valid = act_fire || pre_fire || rd_fire || wr_fire;

  always_comb begin
    if (act_fire)     cmd_kind = CMD_ACT;
    else if (rd_fire) cmd_kind = CMD_RD;
    else if (wr_fire) cmd_kind = CMD_WR;
    else              cmd_kind = CMD_PRE;
  end

  assign cmd_row    = lat_row;
  assign cmd_col    = lat_col;
  assign cmd_wdata  = lat_wdata;
  assign rsp_status = lat_kind;
  assign rsp_rdata  = lat_wr ? '0 : bank_rdata;

  AST_ACCEPT_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R10
  AST_SINGLE_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_fire, pre_fire, rd_fire, wr_fire})); // R2

endmodule

// File: rtl/dram_bank_ctrl.sv
module dram_bank_ctrl
  import dbc_pkg::*;
#(
  parameter int unsigned ROW_W     = 4,
  parameter int unsigned COL_W     = 3,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RP      = 2,
  parameter int unsigned T_RC      = 8,
  parameter int unsigned T_WTR     = 4,
  parameter bit          OPEN_PAGE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              cmd_valid,
  output logic [1:0]        cmd_kind,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic [DATA_W-1:0] bank_rdata
);

  logic         act_fire, pre_fire, rd_fire, wr_fire;
  logic         rcd_ok, rp_ok, rc_ok, wtr_ok;
  logic         row_open;
  logic [ROW_W-1:0] open_row;
  access_kind_e probe_kind;
  access_kind_e status_e;
  bank_cmd_e    kind_e;

  dbc_row_tracker #(.ROW_W(ROW_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .open_fire   (act_fire),
    .close_fire  (pre_fire),
    .open_row_in (cmd_row),
    .probe_row   (req_row),
    .is_open     (row_open),
    .cur_row     (open_row),
    .probe_kind  (probe_kind)
  );

  dbc_gap_timer #(.GAP(T_RCD)) u_rcd (.clk(clk), .rst_n(rst_n), .start(act_fire), .elapsed(rcd_ok));
  dbc_gap_timer #(.GAP(T_RP))  u_rp  (.clk(clk), .rst_n(rst_n), .start(pre_fire), .elapsed(rp_ok));
  dbc_gap_timer #(.GAP(T_RC))  u_rc  (.clk(clk), .rst_n(rst_n), .start(act_fire), .elapsed(rc_ok));
  dbc_gap_timer #(.GAP(T_WTR)) u_wtr (.clk(clk), .rst_n(rst_n), .start(wr_fire),  .elapsed(wtr_ok));

  dbc_sequencer #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .OPEN_PAGE(OPEN_PAGE)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_row    (req_row),
    .req_col    (req_col),
    .req_wdata  (req_wdata),
    .probe_kind (probe_kind),
    .rcd_ok     (rcd_ok),
    .rp_ok      (rp_ok),
    .rc_ok      (rc_ok),
    .wtr_ok     (wtr_ok),
    .bank_rdata (bank_rdata),
    .act_fire   (act_fire),
    .pre_fire   (pre_fire),
    .rd_fire    (rd_fire),
    .wr_fire    (wr_fire),
    .cmd_valid  (cmd_valid),
    .cmd_kind   (kind_e),
    .cmd_row    (cmd_row),
    .cmd_col    (cmd_col),
    .cmd_wdata  (cmd_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_status (status_e),
    .rsp_rdata  (rsp_rdata)
  );

  assign cmd_kind   = kind_e;
  assign rsp_status = status_e;

  AST_COL_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire || wr_fire) |-> row_open); // R2
  AST_HIT_ROW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire || wr_fire) |-> (open_row == cmd_row)); // R2

  generate
    if (T_RCD > 1) begin : g_rcd
      AST_RCD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |=> !(rd_fire || wr_fire)); // R9
    end
    if (T_RP > 1) begin : g_rp
      AST_RP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        pre_fire |=> !act_fire); // R9
    end
    if (T_WTR > 1) begin : g_wtr
      AST_WTR_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> !rd_fire); // R8
    end
    if (T_RC > 1) begin : g_rc
      AST_RC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |=> !act_fire); // R7
    end
    if (OPEN_PAGE) begin : g_open
      AST_ROW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> row_open); // R3
    end else begin : g_close
      AST_ROW_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !row_open); // R6
    end
  endgenerate

endmodule

// File: tb/sim_dram_bank_ctrl.sv
module sim_bank_model #(
  parameter int ROW_W = 4, parameter int COL_W = 3, parameter int DATA_W = 8,
  parameter int T_RCD = 3, parameter int T_RP = 2, parameter int T_RC = 8,
  parameter int T_WTR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int ROWS = 1 << ROW_W;
  localparam int COLS = 1 << COL_W;

  logic [DATA_W-1:0] cells  [ROWS][COLS];
  logic [DATA_W-1:0] rowbuf [COLS];
  logic              open;
  logic [ROW_W-1:0]  open_r;
  int cyc, last_act, last_pre, last_wr;
  int rule_errs, n_act, n_pre;

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        cells[r][c] = DATA_W'((r * 16 + c) ^ 8'h5A);
    open = 0; open_r = '0; rdata = '0;
    cyc = 0; last_act = -1000; last_pre = -1000; last_wr = -1000;
    rule_errs = 0; n_act = 0; n_pre = 0;
  end

  always @(posedge clk) begin : rules
    int viol;
    viol = 0;
    if (!rst_n) begin
      open <= 1'b0;
    end else begin
      cyc <= cyc + 1;
      if (cmd_valid) begin
        case (cmd_kind)
          2'd0: begin
            if (open) viol++;
            if (cyc - last_act < T_RC) viol++;
            if (cyc - last_pre < T_RP) viol++;
            open <= 1'b1; open_r <= cmd_row; last_act <= cyc; n_act <= n_act + 1;
            for (int c = 0; c < COLS; c++) rowbuf[c] <= cells[cmd_row][c];
          end
          2'd1: begin
            if (!open) viol++;
            if (cyc - last_act < T_RCD) viol++;
            if (cyc - last_wr < T_WTR) viol++;
            rdata <= rowbuf[cmd_col];
          end
          2'd2: begin
            if (!open) viol++;
            if (cyc - last_act < T_RCD) viol++;
            rowbuf[cmd_col] <= cmd_wdata; last_wr <= cyc;
          end
          default: begin
            if (!open) viol++;
            open <= 1'b0; last_pre <= cyc; n_pre <= n_pre + 1;
            for (int c = 0; c < COLS; c++) cells[open_r][c] <= rowbuf[c];
          end
        endcase
      end
      if (viol != 0) $display("bank rule violation at cycle %0d kind %0d", cyc, cmd_kind);
      rule_errs <= rule_errs + viol;
    end
  end
endmodule

module sim_dram_bank_ctrl;
  localparam int ROW_W = 4, COL_W = 3, DATA_W = 8;
  localparam int T_RCD = 3, T_RP = 2, T_RC = 8, T_WTR = 4;
  localparam int ROWS = 1 << ROW_W, COLS = 1 << COL_W;
  localparam int LAT_HIT = 2, LAT_EMPTY = 2 + T_RCD, LAT_CONF = 2 + T_RP + T_RCD;
  localparam int LAT_RAW = (T_WTR - 1 > 2) ? T_WTR - 1 : 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              rv [2];
  logic              rw [2];
  logic [ROW_W-1:0]  rrow [2];
  logic [COL_W-1:0]  rcol [2];
  logic [DATA_W-1:0] rwd [2];
  logic              rdy [2];
  logic              rspv [2];
  logic [1:0]        rsts [2];
  logic [DATA_W-1:0] rdat [2];
  logic              cv [2];
  logic [1:0]        ck [2];
  logic [ROW_W-1:0]  crow [2];
  logic [COL_W-1:0]  ccol [2];
  logic [DATA_W-1:0] cwd [2];
  logic [DATA_W-1:0] brd [2];

  dram_bank_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
    .T_RP(T_RP), .T_RC(T_RC), .T_WTR(T_WTR), .OPEN_PAGE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_ready(rdy[0]), .req_write(rw[0]),
    .req_row(rrow[0]), .req_col(rcol[0]), .req_wdata(rwd[0]), .rsp_valid(rspv[0]),
    .rsp_status(rsts[0]), .rsp_rdata(rdat[0]), .cmd_valid(cv[0]), .cmd_kind(ck[0]),
    .cmd_row(crow[0]), .cmd_col(ccol[0]), .cmd_wdata(cwd[0]), .bank_rdata(brd[0]));

  dram_bank_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
    .T_RP(T_RP), .T_RC(T_RC), .T_WTR(T_WTR), .OPEN_PAGE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_ready(rdy[1]), .req_write(rw[1]),
    .req_row(rrow[1]), .req_col(rcol[1]), .req_wdata(rwd[1]), .rsp_valid(rspv[1]),
    .rsp_status(rsts[1]), .rsp_rdata(rdat[1]), .cmd_valid(cv[1]), .cmd_kind(ck[1]),
    .cmd_row(crow[1]), .cmd_col(ccol[1]), .cmd_wdata(cwd[1]), .bank_rdata(brd[1]));

  sim_bank_model #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
    .T_RP(T_RP), .T_RC(T_RC), .T_WTR(T_WTR)) m0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cv[0]), .cmd_kind(ck[0]), .cmd_row(crow[0]),
    .cmd_col(ccol[0]), .cmd_wdata(cwd[0]), .rdata(brd[0]));

  sim_bank_model #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
    .T_RP(T_RP), .T_RC(T_RC), .T_WTR(T_WTR)) m1 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cv[1]), .cmd_kind(ck[1]), .cmd_row(crow[1]),
    .cmd_col(ccol[1]), .cmd_wdata(cwd[1]), .rdata(brd[1]));

  logic [DATA_W-1:0] shadow [2][ROWS][COLS];
  int total = 0;
  int bad = 0;
  int cycles = 0;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One access on controller s; exp_lat < 0 skips the latency check.
  task automatic access(input int s, input bit wr, input int row, input int col,
                        input int wd, input int exp_st, input int exp_lat, input string tag);
    int n;
    while (!rdy[s]) @(negedge clk);
    rv[s] = 1'b1; rw[s] = wr; rrow[s] = ROW_W'(row); rcol[s] = COL_W'(col); rwd[s] = DATA_W'(wd);
    @(posedge clk);
    @(negedge clk);
    rv[s] = 1'b0;
    chk(rdy[s] == 1'b0, "R10 busy after accept", int'(rdy[s]), 0);
    n = 1;
    while (!rspv[s] && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk(rsts[s] == 2'(exp_st), {tag, " status"}, int'(rsts[s]), exp_st);
    if (exp_lat > 0) chk(n == exp_lat, {tag, " latency"}, n, exp_lat);
    if (wr) begin
      shadow[s][row][col] = DATA_W'(wd);
      chk(rdat[s] == '0, "R11 write rdata", int'(rdat[s]), 0);
    end else begin
      chk(rdat[s] == shadow[s][row][col], "R11 read data", int'(rdat[s]),
          int'(shadow[s][row][col]));
    end
    @(negedge clk);
    chk(rspv[s] == 1'b0, "R10 single response", int'(rspv[s]), 0);
  endtask

  task automatic t_reset;
    chk(rdy[0] && rdy[1], "R1 ready after reset", int'(rdy[0]) + int'(rdy[1]), 2);
    chk(!cv[0] && !cv[1], "R1 no command", int'(cv[0]) + int'(cv[1]), 0);
    chk(!rspv[0] && !rspv[1], "R1 no response", int'(rspv[0]) + int'(rspv[1]), 0);
  endtask

  task automatic t_open_page;
    int acts;
    access(0, 0, 3, 2, 0, 1, LAT_EMPTY, "R1 R4 empty");
    acts = m0.n_act;
    access(0, 0, 3, 5, 0, 0, LAT_HIT, "R3 hit read");
    access(0, 1, 3, 5, 8'hC3, 0, LAT_HIT, "R3 hit write");
    access(0, 0, 3, 5, 0, 0, LAT_RAW, "R8 read after write");
    chk(m0.n_act == acts && m0.n_pre == 0, "R3 no open/close on hits", m0.n_act - acts + m0.n_pre, 0);
    idle(12);
    access(0, 0, 7, 1, 0, 2, LAT_CONF, "R5 conflict");
    chk(m0.n_pre == 1 && m0.n_act == 2, "R5 close then open", m0.n_pre * 10 + m0.n_act, 12);
    access(0, 0, 3, 5, 0, 2, -1, "R5 writeback reread");
    for (int k = 0; k < 4; k++)
      access(0, k[0], 9 + k[0], k, 8'h10 + k, 2, -1, "R7 back-to-back conflict");
    access(0, 0, 10, 1, 0, 0, -1, "R3 hit after conflicts");
  endtask

  task automatic t_close_page;
    access(1, 0, 2, 0, 0, 1, LAT_EMPTY, "R6 first empty");
    chk(m1.open == 1'b0, "R6 bank empty after access", int'(m1.open), 0);
    access(1, 0, 2, 0, 0, 1, -1, "R6 same row still empty");
    access(1, 1, 2, 3, 8'hA5, 1, -1, "R6 write");
    access(1, 0, 2, 3, 0, 1, -1, "R6 read back");
    idle(2);
    chk(m1.n_pre == 4 && m1.n_act == 4, "R6 close per access", m1.n_pre * 10 + m1.n_act, 44);
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      rv[s] = 0; rw[s] = 0; rrow[s] = '0; rcol[s] = '0; rwd[s] = '0;
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          shadow[s][r][c] = DATA_W'((r * 16 + c) ^ 8'h5A);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_open_page();
    t_close_page();
    idle(2);
    chk(m0.rule_errs == 0, "R2 R7 R8 R9 open-page bank rules", m0.rule_errs, 0);
    chk(m1.rule_errs == 0, "R2 R7 R9 close-page bank rules", m1.rule_errs, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles >= 100000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule